// File: doc/BRIEF.md
# Multi-Level Page Permission Accumulator

This block takes the entries of a four-level page-table walk, one per accepted cycle. The walk starts at the top level, level 4, and moves down to level 1. The block folds the permission bits of those entries into one effective permission set for the final translation. Three rules set the result:

- The page is user-accessible only if every visited entry allows user access.
- The page is writable only if every visited entry allows writes.
- The page is non-executable if any visited entry forbids execution.

In this way a restriction placed high in the hierarchy overrides permissive entries below it.

The walk stops at the first entry that is not present, or at the first large-page leaf found below the top level. An entry at level 1 always ends the walk. When the walk stops, a one-cycle done strobe reports the following:

- the effective bits;
- the level where the walk stopped;
- whether the walk ended on a missing page rather than on a translation.

The surrounding walker fetches the entries and issues a start pulse for each new walk. Memory access, address formation and TLB storage sit outside the block.

Top module: `perm_walk_acc`

## Requirements
- R1: A start pulse resets the accumulated permissions to fully permissive (user 1, write 1, no-execute 0). The first entry accepted after it is treated as level 4.
- R2: The effective user bit reported with done is the AND of the user bit of every entry accepted in the walk.
- R3: The effective write bit reported with done is the AND of the write bit of every entry accepted in the walk.
- R4: The effective no-execute bit reported with done is the OR of the no-execute bit of every entry accepted in the walk.
- R5: A present entry with its leaf bit set ends the walk at level 3 or level 2. The leaf bit is ignored at level 4. A present level-1 entry always ends the walk.
- R6: A non-present entry ends the walk at its level with not_present = 1. The effective bits are then forced to user 0, write 0, no-execute 1. A walk ending on a present entry reports not_present = 0.
- R7: done is high for exactly one cycle, in the cycle after the clock edge that accepts the terminating entry. stop_level holds the stopping level minus one: level 4 = 3, level 1 = 0.
- R8: Entries presented with ent_valid while no walk is active are ignored and produce no done. This covers entries before the first start and entries after a walk has ended.
- R9: A start pulse during an active walk aborts it, and the following result reflects only the entries accepted after the new start. An entry presented in the same cycle as start is ignored.
- R10: While rst is high and after it is released, done, not_present, the effective bits and stop_level are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new walk (aborts any active walk) |
| ent_valid | input | 1 | An entry is presented this cycle |
| ent_present | input | 1 | Entry present bit |
| ent_write | input | 1 | Entry write-enable bit |
| ent_user | input | 1 | Entry user-accessible bit |
| ent_nx | input | 1 | Entry no-execute bit |
| ent_leaf | input | 1 | Entry maps a large page (leaf) |
| done | output | 1 | One-cycle result strobe |
| eff_user | output | 1 | Effective user-accessible permission |
| eff_write | output | 1 | Effective write permission |
| eff_nx | output | 1 | Effective no-execute |
| not_present | output | 1 | Walk ended on a non-present entry |
| stop_level | output | 2 | Stopping level minus one |

## Verification
Two situations are the hardest to bring about from the ports.

- **Restart mid-walk.** A start must arrive while a walk is half done, and the stale accumulation must not leak into the new result. The bench drives two permission-stripping entries, then raises start together with a valid restrictive entry. It then checks that a fully permissive walk still reports full permission.
- **Entries after the walk ends.** Entries keep arriving after the walk has stopped on a leaf or a missing page. Every walk in the bench keeps driving its remaining entries after the stop and confirms that done stays low.

Random walks with idle gaps between entries cover the fold rules under many leaf and present patterns.

// File: rtl/pwa_pkg.sv
package pwa_pkg;

    typedef struct packed {
        logic present;
        logic wr;
        logic usr;
        logic nx;
        logic leaf;
    } pte_bits_t;

    typedef struct packed {
        logic usr;
        logic wr;
        logic nx;
    } perm_t;

    localparam perm_t PERM_OPEN = '{usr: 1'b1, wr: 1'b1, nx: 1'b0};
    localparam perm_t PERM_DENY = '{usr: 1'b0, wr: 1'b0, nx: 1'b1};

    function automatic perm_t perm_merge(input perm_t acc, input pte_bits_t e);
        perm_t r;
        r.usr = acc.usr & e.usr;
        r.wr  = acc.wr  & e.wr;
        r.nx  = acc.nx  | e.nx;
        return r;
    endfunction

endpackage

// File: rtl/pwa_fold.sv
module pwa_fold
    import pwa_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int LVL_W  = $clog2(LEVELS)
) (
    input  perm_t      acc,
    input  pte_bits_t  ent,
    input  logic [LVL_W-1:0] level,
    output perm_t      nxt,
    output logic       ends,
    output logic       miss
);
    logic [LEVELS-1:0] leaf_ok;

    // Large-page leaves are honoured below the top level only.
    for (genvar g = 0; g < LEVELS; g++) begin : g_leaf
        assign leaf_ok[g] = (g != LEVELS - 1);
    end

    always_comb begin
        nxt  = perm_merge(acc, ent);
        miss = !ent.present;
        ends = miss || (level == '0) || (ent.leaf && leaf_ok[level]);
    end
endmodule

// File: rtl/pwa_seq.sv
module pwa_seq
    import pwa_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int LVL_W  = $clog2(LEVELS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             ent_valid,
    input  perm_t            nxt,
    input  logic             ends,
    output logic             take,
    output logic [LVL_W-1:0] level,
    output perm_t            acc
);
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

    logic busy;

    assign take = busy && ent_valid && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            level <= TOP_LVL;
            acc   <= PERM_OPEN;
        end else if (start) begin
            busy  <= 1'b1;
            level <= TOP_LVL;
            acc   <= PERM_OPEN;
        end else if (take) begin
            acc <= nxt;
            if (ends) begin
                busy <= 1'b0;
            end else begin
                level <= level - 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwa_result.sv
module pwa_result
    import pwa_pkg::*;
#(
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             miss,
    input  perm_t            nxt,
    input  logic [LVL_W-1:0] level,
    output logic             done,
    output perm_t            eff,
    output logic             np,
    output logic [LVL_W-1:0] stop_lvl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            eff      <= '0;
            np       <= 1'b0;
            stop_lvl <= '0;
        end else begin
            done <= fire;
            if (fire) begin
                eff      <= miss ? PERM_DENY : nxt;
                np       <= miss;
                stop_lvl <= level;
            end
        end
    end
endmodule

// File: rtl/perm_walk_acc.sv
module perm_walk_acc
    import pwa_pkg::*;
#(
    parameter int LEVELS = 4,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             ent_valid,
    input  logic             ent_present,
    input  logic             ent_write,
    input  logic             ent_user,
    input  logic             ent_nx,
    input  logic             ent_leaf,
    output logic             done,
    output logic             eff_user,
    output logic             eff_write,
    output logic             eff_nx,
    output logic             not_present,
    output logic [LVL_W-1:0] stop_level
);
    pte_bits_t        ent;
    perm_t            acc, nxt, eff;
    logic             ends, miss, take;
    logic [LVL_W-1:0] level;

    assign ent = '{present: ent_present, wr: ent_write, usr: ent_user,
                   nx: ent_nx, leaf: ent_leaf};

    pwa_fold #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_fold (
        .acc(acc), .ent(ent), .level(level),
        .nxt(nxt), .ends(ends), .miss(miss)
    );

    pwa_seq #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .ent_valid(ent_valid),
        .nxt(nxt), .ends(ends), .take(take), .level(level), .acc(acc)
    );

    pwa_result #(.LVL_W(LVL_W)) u_res (
        .clk(clk), .rst(rst), .fire(take && ends), .miss(miss),
        .nxt(nxt), .level(level), .done(done), .eff(eff),
        .np(not_present), .stop_lvl(stop_level)
    );

    assign eff_user  = eff.usr;
    assign eff_write = eff.wr;
    assign eff_nx    = eff.nx;
endmodule

// File: rtl/pwa_checker.sv
module pwa_checker #(
    parameter int LVL_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             ent_valid,
    input logic             done,
    input logic             eff_user,
    input logic             eff_write,
    input logic             eff_nx,
    input logic             not_present,
    input logic [LVL_W-1:0] stop_level
);
    localparam logic [LVL_W-1:0] TOP = '1;

    // R7: the strobe never lasts two cycles
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: a missing page reports the fully restrictive set
    p_miss_deny_r6: assert property (@(posedge clk) disable iff (rst)
        (done && not_present) |-> (!eff_user && !eff_write && eff_nx));

    // R5: a walk cannot stop at the top level on a present entry
    p_top_leaf_r5: assert property (@(posedge clk) disable iff (rst)
        (done && stop_level == TOP) |-> not_present);

    // R8: every result follows an entry offered in the previous cycle
    p_needs_entry_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(ent_valid));

    // R9: an entry offered together with start is never accepted
    p_start_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> !done);
endmodule

bind perm_walk_acc pwa_checker #(.LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .ent_valid(ent_valid),
    .done(done), .eff_user(eff_user), .eff_write(eff_write),
    .eff_nx(eff_nx), .not_present(not_present), .stop_level(stop_level)
);

// File: tb/perm_walk_acc_tb.sv
module perm_walk_acc_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst, start, ent_valid;
    logic       ent_present, ent_write, ent_user, ent_nx, ent_leaf;
    logic       done, eff_user, eff_write, eff_nx, not_present;
    logic [1:0] stop_level;

    int n_chk = 0;
    int n_bad = 0;

    perm_walk_acc u_dut (
        .clk(clk), .rst(rst), .start(start), .ent_valid(ent_valid),
        .ent_present(ent_present), .ent_write(ent_write), .ent_user(ent_user),
        .ent_nx(ent_nx), .ent_leaf(ent_leaf), .done(done),
        .eff_user(eff_user), .eff_write(eff_write), .eff_nx(eff_nx),
        .not_present(not_present), .stop_level(stop_level)
    );

    // entry bit order in bench: {present, write, user, nx, leaf}
    typedef logic [4:0] ent_t;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model: index of terminating entry plus expected outputs.
    function automatic int model(input ent_t e[4], output logic u, output logic w,
                                 output logic x, output logic np);
        u = 1'b1; w = 1'b1; x = 1'b0; np = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (!e[i][4]) begin
                np = 1'b1; u = 1'b0; w = 1'b0; x = 1'b1;
                return i;
            end
            u = u & e[i][2];
            w = w & e[i][3];
            x = x | e[i][1];
            if (i == 3 || (i > 0 && e[i][0])) return i;
        end
        return 3;
    endfunction

    task automatic drive_ent(input ent_t e);
        @(negedge clk);
        ent_valid = 1'b1;
        {ent_present, ent_write, ent_user, ent_nx, ent_leaf} = e;
    endtask

    task automatic idle_cycle(input string req);
        @(negedge clk);
        ent_valid = 1'b0;
        @(posedge clk); #1;
        chk(done == 1'b0, req, done, 0);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1; ent_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Feed all four entries (gaps optional); check done timing and result.
    task automatic run_walk(input ent_t e[4], input bit gaps, input string tag);
        logic u, w, x, np;
        int stop;
        stop = model(e, u, w, x, np);
        for (int i = 0; i < 4; i++) begin
            if (gaps && ($urandom % 3 == 0)) idle_cycle("R8 gap");
            drive_ent(e[i]);
            @(posedge clk); #1;
            if (i == stop) begin
                chk(done == 1'b1, {tag, " R7 done"}, done, 1);
                chk(eff_user == u, {tag, " R2 user"}, eff_user, u);
                chk(eff_write == w, {tag, " R3 write"}, eff_write, w);
                chk(eff_nx == x, {tag, " R4 nx"}, eff_nx, x);
                chk(not_present == np, {tag, " R6 np"}, not_present, np);
                chk(stop_level == 2'(3 - stop), {tag, " R7 level"}, stop_level, 3 - stop);
            end else begin
                chk(done == 1'b0, {tag, i > stop ? " R8 after end" : " R5 continue"}, done, 0);
            end
        end
        @(negedge clk);
        ent_valid = 1'b0;
        @(posedge clk); #1;
        chk(done == 1'b0, {tag, " R7 one cycle"}, done, 0);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        ent_t e[4];
        void'($urandom(32'd1234));
        rst = 1'b1; start = 1'b0; ent_valid = 1'b0;
        {ent_present, ent_write, ent_user, ent_nx, ent_leaf} = '0;
        repeat (3) @(posedge clk);
        #1;
        chk(done == 0 && not_present == 0 && stop_level == 0 && eff_user == 0,
            "R10 reset", done, 0);
        @(negedge clk); rst = 1'b0;

        // R8: entries before any start are ignored
        drive_ent(5'b11110);
        @(posedge clk); #1;
        chk(done == 1'b0, "R8 idle entry", done, 0);

        // R1: fully permissive four-level walk
        e = '{5'b11100, 5'b11100, 5'b11100, 5'b11100};
        pulse_start(); run_walk(e, 1'b0, "R1 open");
        // R2: top-level user restriction wins
        e = '{5'b11000, 5'b11100, 5'b11100, 5'b11100};
        pulse_start(); run_walk(e, 1'b0, "R2 top user");
        // R3/R5: leaf at level 3 stops the walk; rest ignored
        e = '{5'b11100, 5'b10101, 5'b11100, 5'b11100};
        pulse_start(); run_walk(e, 1'b0, "R5 leaf3");
        // R5: leaf at level 4 ignored; R4 nx at level 2
        e = '{5'b11101, 5'b11100, 5'b11110, 5'b11100};
        pulse_start(); run_walk(e, 1'b0, "R5 top leaf");
        // R6: not present at level 2
        e = '{5'b11100, 5'b11100, 5'b01100, 5'b11100};
        pulse_start(); run_walk(e, 1'b0, "R6 miss2");
        // R6: not present at top
        e = '{5'b01100, 5'b11100, 5'b11100, 5'b11100};
        pulse_start(); run_walk(e, 1'b0, "R6 miss4");

        // R9: abort mid-walk; entry with start is ignored
        pulse_start();
        drive_ent(5'b10010); @(posedge clk); #1;
        drive_ent(5'b10010); @(posedge clk); #1;
        chk(done == 1'b0, "R9 partial", done, 0);
        @(negedge clk);
        start = 1'b1; ent_valid = 1'b1;
        {ent_present, ent_write, ent_user, ent_nx, ent_leaf} = 5'b00010;
        @(negedge clk);
        start = 1'b0; ent_valid = 1'b0;
        e = '{5'b11100, 5'b11100, 5'b11100, 5'b11100};
        run_walk(e, 1'b0, "R9 restart");

        // Random walks
        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < 4; i++) begin
                e[i] = 5'($urandom);
                if ($urandom % 8 != 0) e[i][4] = 1'b1;
                if ($urandom % 3 != 0) e[i][0] = 1'b0;
            end
            pulse_start();
            run_walk(e, 1'b1, "R2 R3 R4 rand");
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule